// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between the execute stage of a 32-bit processor and a byte-addressed 32-bit data memory port. Each request carries a base register value and a signed displacement. The unit adds them to form the effective address and sends the word-aligned address to memory. Memory is little endian: byte lane 0 holds the lowest address of a word, and consecutive words are 4 addresses apart. There is no alignment restriction. A byte or halfword may start at any offset as long as it stays inside one word. An access that would spill into the next word raises a flag and is not performed.

For stores, the unit shifts the register data so that its low byte lands in the lane of the effective address. It also drives a per-lane write enable mask. Stores have no signed or unsigned form.

For loads, the memory answers one cycle after the request. The unit keeps the access shape of the request in a small response state machine. When the read word returns, it shifts the word right by the byte offset and fills the upper bits with the sign bit or with zeros.

The state machine has two states:
- `ST_IDLE`: no load response is due.
- `ST_LOAD_RESP`: the read word on the memory port belongs to the load accepted in the previous cycle.

Its transitions are:
- `IDLE->LOAD_RESP`: taken when a load that does not cross a word is accepted.
- `LOAD_RESP->LOAD_RESP`: taken when another such load is accepted while a response is being delivered, so back-to-back loads are supported.
- `LOAD_RESP->IDLE`: taken on any other cycle.
- `ANY->IDLE`: taken on reset.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_imm`, with `req_imm` sign-extended from 12 bits. `mem_addr` is the effective address with its two low bits cleared. Its offset is the effective address modulo 4.
- R2: A valid store that stays inside one word drives `mem_we` with 1, 2 or 4 set bits for size `2'b00` (byte), `2'b01` (halfword) or `2'b10` (word). These bits start at lane offset, where bit i enables the memory byte at offset i. In every other case `mem_we` is 0.
- R3: On a store, `mem_wdata` equals `req_wdata` shifted left by 8 times the offset, truncated to 32 bits.
- R4: `misaligned` is 1 for a valid request in any of three cases: a halfword at offset 3, a word at any nonzero offset, or size `2'b11`. A flagged request drives `mem_we` to 0 and `mem_re` to 0.
- R5: A valid load that stays inside one word drives `mem_re` high in the same cycle. `load_valid` is then high in the next cycle.
- R6: When the unsigned flag is 0, a byte load returns the byte at the offset in bits 7:0. A halfword load returns the two bytes starting at the offset in bits 15:0, lower address in bits 7:0. Both copy the top bit of the loaded value into all upper bits.
- R7: When the unsigned flag is 1, byte and halfword loads fill the upper bits with zeros.
- R8: A word load returns the full read word, whatever the unsigned flag.
- R9: During and right after reset, `load_valid` is 0 and the machine is in `ST_IDLE`.
- R10: A misaligned load, a store or an idle cycle is never followed by `load_valid` in the next cycle.
- R11: The unsigned flag has no effect on store enables or store data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| req_unsigned | input | 1 | Zero-extend byte/halfword loads |
| req_base | input | 32 | Base register value |
| req_imm | input | 12 | Signed displacement |
| req_wdata | input | 32 | Store register data |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_re` |
| misaligned | output | 1 | Request crosses a word or has an illegal size |
| load_valid | output | 1 | Load result valid this cycle |
| load_data | output | 32 | Extended load result |

## Verification
The assertions take for granted that the memory returns the read word exactly one cycle after `mem_re`. They also assume that the request fields stay stable within a cycle, so the registered shape of a load matches the previous cycle's inputs. The bench drives every request at the falling edge and holds it for one full cycle. It presents the matching read word in the following cycle, and releases `req_valid` between table entries except in the back-to-back load test.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    always_comb begin
        imm_ext  = {{EXT_W{imm[IMM_W-1]}}, imm};
        eff_addr = base + imm_ext;
    end
endmodule

// File: rtl/lsu_span_check.sv
module lsu_span_check
    import lsu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             crosses,
    output logic [LANES-1:0] lane_mask
);
    localparam int CNT_W = OFF_W + 2;

    logic [CNT_W-1:0] nbytes;
    logic [CNT_W-1:0] end_pos;
    logic             illegal;

    always_comb begin
        illegal = 1'b0;
        unique case (size)
            SZ_BYTE: nbytes = CNT_W'(1);
            SZ_HALF: nbytes = CNT_W'(2);
            SZ_WORD: nbytes = CNT_W'(LANES);
            default: begin
                nbytes  = CNT_W'(0);
                illegal = 1'b1;
            end
        endcase
        end_pos = CNT_W'(off) + nbytes;
        crosses = illegal || (end_pos > CNT_W'(LANES));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[i] = (CNT_W'(i) >= CNT_W'(off)) && (CNT_W'(i) < end_pos);
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int OFF_W  = 2
) (
    input  logic              enable,
    input  logic [OFF_W-1:0]  off,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  we,
    output logic [DATA_W-1:0] lane_data
);
    always_comb begin
        lane_data = wdata << {off, 3'b000};
        we        = enable ? lane_mask : '0;
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  off,
    input  acc_size_e         size,
    input  logic              zero_ext,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] shifted;
    logic              fill_b;
    logic              fill_h;

    always_comb begin
        shifted = rdata >> {off, 3'b000};
        fill_b  = !zero_ext && shifted[7];
        fill_h  = !zero_ext && shifted[15];
        unique case (size)
            SZ_BYTE: data = {{(DATA_W-8){fill_b}}, shifted[7:0]};
            SZ_HALF: data = {{(DATA_W-16){fill_h}}, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic [DATA_W/8-1:0] mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              misaligned,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [ADDR_W-1:0] eff_addr;
    logic [OFF_W-1:0]  off;
    logic              crosses;
    logic [LANES-1:0]  lane_mask;
    logic              store_go;
    logic              load_go;
    acc_size_e         size_e;

    resp_state_e       state_q, state_d;
    logic [OFF_W-1:0]  ctx_off_q;
    acc_size_e         ctx_size_q;
    logic              ctx_zext_q;

    assign size_e = acc_size_e'(req_size);
    assign off    = eff_addr[OFF_W-1:0];

    lsu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
        .base     (req_base),
        .imm      (req_imm),
        .eff_addr (eff_addr)
    );

    lsu_span_check #(.LANES(LANES), .OFF_W(OFF_W)) u_span (
        .size      (size_e),
        .off       (off),
        .crosses   (crosses),
        .lane_mask (lane_mask)
    );

    assign misaligned = req_valid && crosses;
    assign store_go   = req_valid && req_is_store && !crosses;
    assign load_go    = req_valid && !req_is_store && !crosses;

    lsu_store_lane #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_stl (
        .enable    (store_go),
        .off       (off),
        .lane_mask (lane_mask),
        .wdata     (req_wdata),
        .we        (mem_we),
        .lane_data (mem_wdata)
    );

    assign mem_addr = {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_re   = load_go;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = load_go ? ST_LOAD_RESP : ST_IDLE;
            ST_LOAD_RESP: state_d = load_go ? ST_LOAD_RESP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register and captured load shape
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ctx_off_q  <= '0;
            ctx_size_q <= SZ_BYTE;
            ctx_zext_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_go) begin
                ctx_off_q  <= off;
                ctx_size_q <= size_e;
                ctx_zext_q <= req_unsigned;
            end
        end
    end

    lsu_load_extract #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_lext (
        .rdata    (mem_rdata),
        .off      (ctx_off_q),
        .size     (ctx_size_q),
        .zero_ext (ctx_zext_q),
        .data     (load_data)
    );

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_LOAD_RESP: load_valid = 1'b1;
            default:      load_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_is_store,
    input logic [1:0]        req_size,
    input logic              req_unsigned,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic [DATA_W/8-1:0] mem_we,
    input logic              misaligned,
    input logic              load_valid,
    input logic [DATA_W-1:0] load_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    p_word_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFF_W-1:0] == '0);

    p_we_only_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> (req_valid && req_is_store && !misaligned));

    p_we_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> ($countones(mem_we) == 1 || $countones(mem_we) == 2
                            || $countones(mem_we) == LANES));

    p_misaligned_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (mem_we == '0 && !mem_re));

    p_load_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && !misaligned) |=> load_valid);

    p_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_is_store && !misaligned) |=> !load_valid);

    p_sign_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && $past(req_size == 2'b00 && !req_unsigned))
        |-> (load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}}));

    p_zero_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && $past(req_size == 2'b00 && req_unsigned))
        |-> (load_data[DATA_W-1:8] == '0));
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .mem_addr     (mem_addr),
    .mem_re       (mem_re),
    .mem_we       (mem_we),
    .misaligned   (misaligned),
    .load_valid   (load_valid),
    .load_data    (load_data)
);

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic        us;
        logic [11:0] imm;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [31:0] e_addr;
        logic [3:0]  e_we;
        logic [31:0] e_wd;
        logic        e_mis;
        logic [31:0] e_ld;
    } vec_t;

    localparam int NV = 19;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 1'b0, 12'h000, 32'h0, 32'h8899AABB, 32'h1000, 4'h0, 32'h0, 1'b0, 32'hFFFFFFBB},
        '{1'b0, 2'd0, 1'b1, 12'h001, 32'h0, 32'h8899AABB, 32'h1000, 4'h0, 32'h0, 1'b0, 32'h000000AA},
        '{1'b0, 2'd0, 1'b0, 12'h002, 32'h0, 32'h7F123456, 32'h1000, 4'h0, 32'h0, 1'b0, 32'h00000012},
        '{1'b0, 2'd1, 1'b0, 12'h002, 32'h0, 32'h8899AABB, 32'h1000, 4'h0, 32'h0, 1'b0, 32'hFFFF8899},
        '{1'b0, 2'd1, 1'b1, 12'h001, 32'h0, 32'h8899AABB, 32'h1000, 4'h0, 32'h0, 1'b0, 32'h000099AA},
        '{1'b0, 2'd2, 1'b1, 12'h004, 32'h0, 32'h8899AABB, 32'h1004, 4'h0, 32'h0, 1'b0, 32'h8899AABB},
        '{1'b0, 2'd1, 1'b0, 12'hFFF, 32'h0, 32'h8899AABB, 32'h0FFC, 4'h0, 32'h0, 1'b1, 32'h0},
        '{1'b0, 2'd2, 1'b0, 12'h002, 32'h0, 32'h8899AABB, 32'h1000, 4'h0, 32'h0, 1'b1, 32'h0},
        '{1'b0, 2'd1, 1'b0, 12'h000, 32'h0, 32'h7F123456, 32'h1000, 4'h0, 32'h0, 1'b0, 32'h00003456},
        '{1'b0, 2'd0, 1'b0, 12'h003, 32'h0, 32'h7F123456, 32'h1000, 4'h0, 32'h0, 1'b0, 32'h0000007F},
        '{1'b1, 2'd0, 1'b0, 12'h003, 32'hCAFE1234, 32'h0, 32'h1000, 4'h8, 32'h34000000, 1'b0, 32'h0},
        '{1'b1, 2'd1, 1'b0, 12'h002, 32'hCAFE1234, 32'h0, 32'h1000, 4'hC, 32'h12340000, 1'b0, 32'h0},
        '{1'b1, 2'd1, 1'b0, 12'h001, 32'hCAFE1234, 32'h0, 32'h1000, 4'h6, 32'hFE123400, 1'b0, 32'h0},
        '{1'b1, 2'd2, 1'b0, 12'hFFC, 32'hCAFE1234, 32'h0, 32'h0FFC, 4'hF, 32'hCAFE1234, 1'b0, 32'h0},
        '{1'b1, 2'd2, 1'b0, 12'h001, 32'hCAFE1234, 32'h0, 32'h1000, 4'h0, 32'h0, 1'b1, 32'h0},
        '{1'b1, 2'd0, 1'b1, 12'h005, 32'hCAFE1234, 32'h0, 32'h1004, 4'h2, 32'hFE123400, 1'b0, 32'h0},
        '{1'b0, 2'd3, 1'b0, 12'h000, 32'h0, 32'h8899AABB, 32'h1000, 4'h0, 32'h0, 1'b1, 32'h0},
        '{1'b1, 2'd0, 1'b0, 12'h7FF, 32'hCAFE1234, 32'h0, 32'h17FC, 4'h8, 32'h34000000, 1'b0, 32'h0},
        '{1'b1, 2'd1, 1'b0, 12'h003, 32'hCAFE1234, 32'h0, 32'h1000, 4'h0, 32'h0, 1'b1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = BASE;
    logic [11:0] req_imm = 12'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] mem_addr;
    logic        mem_re;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        misaligned;
    logic        load_valid;
    logic [31:0] load_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_align_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_imm(req_imm), .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .misaligned(misaligned), .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic st, input logic [1:0] sz,
                         input logic us, input logic [11:0] imm, input logic [31:0] wd);
        req_valid = v; req_is_store = st; req_size = sz;
        req_unsigned = us; req_imm = imm; req_wdata = wd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R9 reset load_valid", {31'b0, load_valid}, 32'h0);
        chk(mem_we == 4'h0, "R9 reset we", {28'b0, mem_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R9 after reset", {31'b0, load_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VEC[i].st, VEC[i].sz, VEC[i].us, VEC[i].imm, VEC[i].wd);
            #1;
            chk(mem_addr == VEC[i].e_addr, "R1 address", mem_addr, VEC[i].e_addr);
            chk(misaligned == VEC[i].e_mis, "R4 misaligned", {31'b0, misaligned},
                {31'b0, VEC[i].e_mis});
            chk(mem_we == VEC[i].e_we, VEC[i].us ? "R11 store enables" : "R2 store enables",
                {28'b0, mem_we}, {28'b0, VEC[i].e_we});
            if (VEC[i].st && !VEC[i].e_mis)
                chk(mem_wdata == VEC[i].e_wd, VEC[i].us ? "R11 store data" : "R3 store data",
                    mem_wdata, VEC[i].e_wd);
            chk(mem_re == (!VEC[i].st && !VEC[i].e_mis), "R5 mem_re", {31'b0, mem_re},
                {31'b0, !VEC[i].st && !VEC[i].e_mis});
            @(negedge clk);
            drive(1'b0, 1'b0, 2'd0, 1'b0, 12'h0, 32'h0);
            mem_rdata = VEC[i].rd;
            #1;
            if (!VEC[i].st && !VEC[i].e_mis) begin
                chk(load_valid == 1'b1, "R5 load_valid", {31'b0, load_valid}, 32'h1);
                chk(load_data == VEC[i].e_ld,
                    (VEC[i].sz == 2'd2) ? "R8 word load" : (VEC[i].us ? "R7 zero extend"
                                                                       : "R6 sign extend"),
                    load_data, VEC[i].e_ld);
            end else begin
                chk(load_valid == 1'b0, "R10 no response", {31'b0, load_valid}, 32'h0);
            end
        end

        // back-to-back loads (R5, R6, R7)
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd0, 1'b1, 12'h001, 32'h0);
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd1, 1'b0, 12'h002, 32'h0);
        mem_rdata = 32'h8899AABB;
        #1;
        chk(load_valid && load_data == 32'h000000AA, "R7 back-to-back first", load_data,
            32'h000000AA);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 1'b0, 12'h0, 32'h0);
        #1;
        chk(load_valid && load_data == 32'hFFFF8899, "R6 back-to-back second", load_data,
            32'hFFFF8899);
        @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R10 idle after loads", {31'b0, load_valid}, 32'h0);

        // store fields without req_valid: no enables (R2)
        drive(1'b0, 1'b1, 2'd2, 1'b0, 12'h000, 32'hDEADBEEF);
        #1;
        chk(mem_we == 4'h0, "R2 idle store ignored", {28'b0, mem_we}, 32'h0);

        // reset during a pending response (R9)
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd2, 1'b0, 12'h000, 32'h0);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 1'b0, 12'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R9 reset clears response", {31'b0, load_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
            wait (done);
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule